// File: doc/BRIEF.md
# BT.656 Active Video Line Extractor

This block sits behind an analog video decoder that delivers 8-bit multiplexed 4:2:2 samples on its line-locked clock. It frames lines using only the timing reference codes embedded in the byte stream, and uses no separate sync pin. A reference code is a three-byte preamble followed by a status byte. The status byte carries the field bit F, the vertical-blanking bit V, the start/end bit H, and four protection bits. The block decodes the status byte and checks its protection bits. After a start code for a visible line, it passes the samples out with valid, start-of-line, end-of-line, luma and field flags.

Each visible line is measured in byte samples and compared against a nominal length of 1440 (720 pixels of two bytes each). A mismatch raises a one-cycle error pulse that carries the measured count. End codes update a field/vertical-blanking state pair, and a pulse marks each change of that pair. Preamble bytes are held in a short delay line, so they never reach the pixel output. A preamble that turns out to be broken is replayed as ordinary data.

Top module: `active_line_extract`

## Requirements
- R1: After reset every output is 0 except `vbl_state`, which is 1. No `pix_valid` is raised until a valid start code for a visible line has been decoded.
- R2: A reference code is FF, 00, 00, S with S[7]=1, where S[6]=F, S[5]=V and S[4]=H. S[3:0] must equal {V^H, F^H, F^V, F^V^H}. If it does not, `code_err` pulses and the code changes no state and raises no other flag.
- R3: The four bytes of any reference code, valid or not, never appear as pixel data. FF/00 bytes that do not complete a reference code are passed on as ordinary samples while a line is open.
- R4: A valid start code with V=0 (S = 0x80 or 0xC7) opens a line. Each byte after it is output with `pix_valid` four clock edges after it is sampled, until the next valid code.
- R5: `pix_sol` marks the first sample of a line. `pix_eol` marks the sample just before the valid code that closes the line. `pix_field` carries the F bit of the line's start code.
- R6: `pix_luma` marks the 2nd, 4th, 6th... samples of a line, which are the Y positions of the sequence Cb, Y, Cr, Y.
- R7: When a valid end code (H=1) closes an open line of N samples with N != 1440, `len_err` pulses with `len_count` = N. With N = 1440 there is no pulse.
- R8: A valid start code that arrives while a line is open closes that line and always pulses `len_err` with its count.
- R9: The sample counter saturates at 4095 instead of wrapping.
- R10: A valid start code with V=1 (for example 0xAB) opens no line, so the samples after it are not output.
- R11: Each valid end code loads `fld_state` with F and `vbl_state` with V. `fld_chg` and `vbl_chg` pulse when the corresponding value changes.
- R12: The number of blanking bytes before a start code has no effect on the output or on the length check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Multiplexed video byte stream |
| pix_data | output | 8 | Active sample, 0 when not valid |
| pix_valid | output | 1 | Active sample present |
| pix_sol | output | 1 | First sample of a line |
| pix_eol | output | 1 | Last sample of a line |
| pix_luma | output | 1 | Sample is a Y value |
| pix_field | output | 1 | Field bit of the current line |
| len_err | output | 1 | Line length mismatch pulse |
| len_count | output | CNT_W | Measured sample count of the last closed line |
| code_err | output | 1 | Reference code with bad protection bits |
| fld_state | output | 1 | Field bit from the last end code |
| vbl_state | output | 1 | Vertical-blanking bit from the last end code |
| fld_chg | output | 1 | Pulse on a change of fld_state |
| vbl_chg | output | 1 | Pulse on a change of vbl_state |

## Verification
The hardest case to reach is a preamble that is interrupted or completed by a non-code byte inside an open line. The held bytes must then come back out in order, with the flags staying aligned. The stimulus injects FF, 00, x sequences and full FF, 00, 00 sequences followed by a byte with bit 7 clear into the middle of a line. It also places a code with bad protection bits mid-line, and places a start code right after an exactly nominal line with no end code. A behavioural queue model checks every output on every clock, and directed counts confirm the totals for each line.

// File: rtl/active_line_extract.sv
module active_line_extract #(
  parameter int ACTIVE_SAMPLES = 1440,
  parameter int CNT_W          = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       din,
  output logic [7:0]       pix_data,
  output logic             pix_valid,
  output logic             pix_sol,
  output logic             pix_eol,
  output logic             pix_luma,
  output logic             pix_field,
  output logic             len_err,
  output logic [CNT_W-1:0] len_count,
  output logic             code_err,
  output logic             fld_state,
  output logic             vbl_state,
  output logic             fld_chg,
  output logic             vbl_chg
);
  localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(ACTIVE_SAMPLES);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0] s0, s1, s2, s3;
  logic       k0, k1, k2, k3;
  logic       open_q, first_q, phase_q, field_q;
  logic [CNT_W-1:0] cnt_q;

  wire       fb = din[6];
  wire       vb = din[5];
  wire       hb = din[4];
  wire [3:0] prot = {vb ^ hb, fb ^ hb, fb ^ vb, fb ^ vb ^ hb};
  wire       pre  = (s2 == 8'hFF) && (s1 == 8'h00) && (s0 == 8'h00) && din[7];
  wire       good = pre && (din[3:0] == prot);
  wire       opens = good && !hb && !vb;
  wire       open_n = good ? opens : open_q;

  wire [CNT_W-1:0] cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  wire [CNT_W-1:0] meas    = k3 ? cnt_inc : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s0, s1, s2, s3} <= '0;
      {k0, k1, k2, k3} <= '0;
      open_q    <= 1'b0;
      first_q   <= 1'b0;
      phase_q   <= 1'b0;
      field_q   <= 1'b0;
      cnt_q     <= '0;
      pix_data  <= '0;
      pix_valid <= 1'b0;
      pix_sol   <= 1'b0;
      pix_eol   <= 1'b0;
      pix_luma  <= 1'b0;
      pix_field <= 1'b0;
      len_err   <= 1'b0;
      len_count <= '0;
      code_err  <= 1'b0;
      fld_state <= 1'b0;
      vbl_state <= 1'b1;
      fld_chg   <= 1'b0;
      vbl_chg   <= 1'b0;
    end else begin
      s0 <= din;
      s1 <= s0;
      s2 <= s1;
      s3 <= s2;
      k0 <= open_n && !pre;
      k1 <= k0 && !pre;
      k2 <= k1 && !pre;
      k3 <= k2 && !pre;

      pix_valid <= k3;
      pix_data  <= k3 ? s3 : 8'h00;
      pix_sol   <= k3 && first_q;
      pix_eol   <= k3 && good && open_q;
      pix_luma  <= k3 && phase_q;
      pix_field <= k3 && field_q;

      if (k3) begin
        cnt_q   <= cnt_inc;
        first_q <= 1'b0;
        phase_q <= ~phase_q;
      end

      len_err  <= 1'b0;
      fld_chg  <= 1'b0;
      vbl_chg  <= 1'b0;
      code_err <= pre && !good;

      if (good) begin
        cnt_q  <= '0;
        open_q <= opens;
        if (open_q) begin
          len_count <= meas;
          len_err   <= (meas != NOMINAL) || !hb;
        end
        if (hb) begin
          fld_state <= fb;
          vbl_state <= vb;
          fld_chg   <= fb != fld_state;
          vbl_chg   <= vb != vbl_state;
        end else if (!vb) begin
          field_q <= fb;
          first_q <= 1'b1;
          phase_q <= 1'b0;
        end
      end
    end
  end
endmodule

module active_line_extract_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic pix_sol,
  input logic pix_eol,
  input logic pix_luma,
  input logic len_err,
  input logic code_err,
  input logic fld_chg,
  input logic vbl_chg
);
  // R5
  eol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eol |-> pix_valid);
  // R5
  sol_chroma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_sol |-> (pix_valid && !pix_luma));
  // R6
  luma_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_luma |=> !pix_luma);
  // R2
  bad_code_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_err |-> (!len_err && !fld_chg && !vbl_chg && !pix_eol));
  // R11
  fld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fld_chg |=> !fld_chg);
endmodule

bind active_line_extract active_line_extract_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
  .pix_eol(pix_eol), .pix_luma(pix_luma), .len_err(len_err),
  .code_err(code_err), .fld_chg(fld_chg), .vbl_chg(vbl_chg)
);

// File: tb/active_line_extract_test.sv
`timescale 1ns/1ps
module active_line_extract_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] din = 8'h10;
  logic [7:0] pix_data;
  logic pix_valid, pix_sol, pix_eol, pix_luma, pix_field;
  logic len_err, code_err, fld_state, vbl_state, fld_chg, vbl_chg;
  logic [11:0] len_count;

  active_line_extract uut (
    .clk(clk), .rst_n(rst_n), .din(din), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_eol(pix_eol),
    .pix_luma(pix_luma), .pix_field(pix_field), .len_err(len_err),
    .len_count(len_count), .code_err(code_err), .fld_state(fld_state),
    .vbl_state(vbl_state), .fld_chg(fld_chg), .vbl_chg(vbl_chg)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: four-entry byte queue plus line state
  byte unsigned md[4];
  bit mk[4];
  int cnt;
  bit inl, first, phase, fcur, fst, vst;
  bit e_valid, e_sol, e_eol, e_luma, e_field, e_le, e_ce, e_fc, e_vc;
  int e_data, e_len;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin md[i] = 0; mk[i] = 0; end
      cnt = 0; inl = 0; first = 0; phase = 0; fcur = 0; fst = 0; vst = 1;
      {e_valid, e_sol, e_eol, e_luma, e_field, e_le, e_ce, e_fc, e_vc} = '0;
      e_data = 0; e_len = 0;
    end else begin
      bit f, v, h, pre, good, ek;
      int meas;
      f = din[6]; v = din[5]; h = din[4];
      pre = md[1] == 8'hFF && md[2] == 0 && md[3] == 0 && din[7];
      good = pre && din[3:0] == {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
      ek = mk[0];
      e_valid = ek; e_data = ek ? md[0] : 0;
      e_sol = ek && first; e_eol = ek && good && inl;
      e_luma = ek && phase; e_field = ek && fcur;
      meas = ek ? ((cnt + 1 > 4095) ? 4095 : cnt + 1) : cnt;
      if (ek) begin cnt = meas; first = 0; phase = !phase; end
      e_le = 0; e_fc = 0; e_vc = 0; e_ce = pre && !good;
      if (good) begin
        if (inl) begin e_len = meas; e_le = (meas != 1440) || !h; end
        cnt = 0;
        if (h) begin e_fc = f != fst; e_vc = v != vst; fst = f; vst = v; end
        else if (!v) begin fcur = f; first = 1; phase = 0; end
        inl = !h && !v;
      end
      md[0] = md[1]; mk[0] = mk[1] && !pre;
      md[1] = md[2]; mk[1] = mk[2] && !pre;
      md[2] = md[3]; mk[2] = mk[3] && !pre;
      md[3] = din;   mk[3] = inl && !pre;
    end
  end

  int n_v, n_l, n_le, n_ce, n_eol, n_fc, n_vc, last_len;
  bit run = 0;

  always @(negedge clk) begin
    if (run) begin
      chk(pix_valid == e_valid, "R4 valid", pix_valid, e_valid);
      chk(pix_data == e_data, "R3 data", pix_data, e_data);
      chk(pix_sol == e_sol && pix_eol == e_eol && pix_field == e_field, "R5 flags",
          {pix_sol, pix_eol, pix_field}, {e_sol, e_eol, e_field});
      chk(pix_luma == e_luma, "R6 luma", pix_luma, e_luma);
      chk(len_err == e_le, "R7 len_err", len_err, e_le);
      if (e_le) chk(len_count == e_len, "R7 len_count", len_count, e_len);
      chk(code_err == e_ce, "R2 code_err", code_err, e_ce);
      chk(fld_chg == e_fc && vbl_chg == e_vc && fld_state == fst && vbl_state == vst,
          "R11 state", {fld_chg, vbl_chg, fld_state, vbl_state}, {e_fc, e_vc, fst, vst});
      n_v += pix_valid; n_l += pix_luma; n_le += len_err; n_ce += code_err;
      n_eol += pix_eol; n_fc += fld_chg; n_vc += vbl_chg;
      if (len_err) last_len = len_count;
    end
  end

  task automatic put(byte unsigned b); @(negedge clk) din = b; endtask
  task automatic code(byte unsigned s); put(8'hFF); put(8'h00); put(8'h00); put(s); endtask
  task automatic samples(int n); for (int i = 0; i < n; i++) put(8'h10 + (i % 200)); endtask
  task automatic blank(int n); for (int i = 0; i < n; i++) put(8'h10); endtask
  task automatic clr(); blank(12); n_v = 0; n_l = 0; n_le = 0; n_ce = 0; n_eol = 0;
    n_fc = 0; n_vc = 0; last_len = -1; endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({pix_valid, pix_sol, pix_eol, len_err, code_err, fld_state, vbl_state} == 7'b0000001,
        "R1 reset", {pix_valid, pix_sol, pix_eol, len_err, code_err, fld_state, vbl_state}, 1);
    rst_n = 1'b1;
    run = 1;
    clr(); blank(50); samples(100); code(8'h9D); samples(50); blank(12);
    chk(n_v == 0, "R1 no data before start", n_v, 0);

    clr(); blank(30); code(8'h80); samples(1440); code(8'h9D); blank(12);
    chk(n_v == 1440, "R4 nominal count", n_v, 1440);
    chk(n_le == 0 && n_eol == 1, "R7 nominal no error", n_le, 0);
    chk(n_l == 720, "R6 luma count", n_l, 720);

    clr(); blank(300); code(8'h80); samples(1440); code(8'h9D); blank(12);
    chk(n_le == 0 && n_v == 1440, "R12 long blanking", n_le, 0);

    clr(); code(8'hC7); samples(1000); code(8'hDA); blank(12);
    chk(n_le == 1 && last_len == 1000, "R7 short line", last_len, 1000);

    clr(); code(8'h80); samples(500); put(8'hFF); put(8'h00); put(8'h37);
    samples(500); code(8'h05); samples(400); code(8'h9D); blank(12);
    chk(n_v == 1407 && last_len == 1407, "R3 broken preamble released", n_v, 1407);

    clr(); code(8'h80); samples(700); code(8'h81); samples(740); code(8'h9D); blank(12);
    chk(n_ce == 1 && n_le == 0 && n_v == 1440, "R2 bad code ignored", n_ce * 10 + n_le, 10);

    clr(); code(8'h80); samples(1440); code(8'h80); samples(1440); code(8'h9D); blank(12);
    chk(n_le == 1 && last_len == 1440, "R8 start closes open line", n_le, 1);

    clr(); code(8'h80); samples(4200); code(8'h9D); blank(12);
    chk(last_len == 4095, "R9 saturation", last_len, 4095);

    clr(); code(8'hAB); samples(200); code(8'hB6); blank(12);
    chk(n_v == 0, "R10 blanking start opens nothing", n_v, 0);
    chk(n_vc == 1 && vbl_state == 1, "R11 vblank entry", n_vc, 1);

    clr(); code(8'hDA); blank(10); code(8'hF1); blank(12);
    chk(n_fc == 1 && n_vc == 2 && fld_state == 1, "R11 field change", n_fc * 10 + n_vc, 12);

    run = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule